// File: doc/BRIEF.md
# Sixteen-bit ALU with per-operation flag update

This block is the arithmetic and logic unit of a small register-to-register processor. Each cycle it takes a 4-bit function code and two operands: A, the value of the destination register, and B, the value of the source register. It returns a result that the surrounding datapath writes back into A's register. The result path is purely combinational, so the result is valid in the same cycle as the inputs.

The block also owns a 3-bit status register with carry (C), overflow (V) and zero (Z) flags. On a clock edge where the enable input is high, only the flags that belong to the executed operation are loaded. Every other flag keeps its value, so later code can still test a carry after a logical operation.

Shift amounts come from operand B. Any amount of the operand width or more saturates. The multiplier can be built either as the synthesis multiply operator or as an explicit shift-and-add array, chosen by a parameter.

Top module: `alu16_flagsel`

## Requirements
- R1: The result is combinational. Function codes: 0001 gives A+B, 0010 gives A-B, 0011 gives the low 16 bits of A*B, 0100 gives A AND B, 0101 gives A OR B, 0110 gives A XOR B, 0111 gives the bitwise inverse of B, and 1100 gives B.
- R2: Code 1000 shifts A left logically and code 1001 shifts A right logically, both by the unsigned value of B. An amount of 16 or more gives 0.
- R3: Code 1011 shifts A right arithmetically by B, filling with A's sign bit, and an amount of 16 or more gives 16 copies of the sign bit. Code 1010 gives A shifted left by B, and an amount of 16 or more gives 0.
- R4: After an enabled add, C holds the unsigned carry out, V holds signed two's-complement overflow, and Z is set exactly when the result is 0.
- R5: After an enabled subtract, C is set exactly when A is below B as unsigned values (borrow), V holds signed overflow of A-B, and Z marks a zero result.
- R6: After an enabled arithmetic shift left, V is set when any bit shifted out, or the new sign bit, differs from A's original sign bit. Z marks a zero result and C is unchanged.
- R7: After an enabled multiply, AND, OR, XOR, NOT, logical shift, arithmetic shift right or move, only Z is loaded, with the zero test of the result, and C and V are unchanged.
- R8: Code 0000, and the unassigned codes 1101 to 1111, output A unchanged and leave all three flags unchanged.
- R9: With enable low, no flag changes on the clock edge, whatever the function code.
- R10: A synchronous active-high reset clears C, V and Z on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| en | input | 1 | Flag load enable for this cycle |
| func | input | 4 | Function code |
| opa | input | 16 | Operand A, the destination register value |
| opb | input | 16 | Operand B, the source register value or the shift amount |
| result | output | 16 | Combinational result |
| flag_c | output | 1 | Carry or borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
Two things can land on the same clock edge: the selective flag load of one operation, and the retained flags of an earlier one. For example, a carry set by an add must survive a following XOR that rewrites only Z. Random sequences of function codes, with enable toggling and shift amounts biased around 15 and 16, create many such adjacent pairs. After every edge, all three flags are compared with a bench model that loads only the mask of the executed operation. Directed cases pin the carry, borrow and overflow boundaries, and a reset pulse in mid-run is checked to clear the flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_NOP = 4'd0,
      OP_ADD = 4'd1,
      OP_SUB = 4'd2,
      OP_MUL = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_NOT = 4'd7,
      OP_LSL = 4'd8,
      OP_LSR = 4'd9,
      OP_ASL = 4'd10,
      OP_ASR = 4'd11,
      OP_MOV = 4'd12
   } op_e;

   typedef struct packed {
      logic c;
      logic v;
      logic z;
   } flags_t;

   // Which flags an operation is allowed to load
   function automatic flags_t flag_mask(input logic [3:0] f);
      flags_t m;
      m = '0;
      case (f)
         OP_ADD, OP_SUB: m = '{c: 1'b1, v: 1'b1, z: 1'b1};
         OP_ASL:         m = '{c: 1'b0, v: 1'b1, z: 1'b1};
         OP_MUL, OP_AND, OP_OR, OP_XOR, OP_NOT,
         OP_LSL, OP_LSR, OP_ASR, OP_MOV:
                         m = '{c: 1'b0, v: 1'b0, z: 1'b1};
         default:        m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic             sum_c,
   output logic             sum_v,
   output logic [WIDTH-1:0] diff,
   output logic             diff_c,
   output logic             diff_v
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0] sum_ext;

   always_comb begin
      sum_ext = {1'b0, a} + {1'b0, b};
      sum     = sum_ext[MSB:0];
      sum_c   = sum_ext[WIDTH];
      sum_v   = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      diff    = a - b;
      diff_c  = (a < b);
      diff_v  = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
   end
endmodule

// File: rtl/alu_multlo.sv
module alu_multlo #(
   parameter int WIDTH     = 16,
   parameter bit MUL_ARRAY = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] prod_lo
);
   generate
      if (MUL_ARRAY) begin : g_array
         logic [WIDTH-1:0] acc [0:WIDTH];
         assign acc[0] = '0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_row
            logic [WIDTH-1:0] pp;
            assign pp         = b[i] ? (a << i) : '0;
            assign acc[i + 1] = acc[i] + pp;
         end
         assign prod_lo = acc[WIDTH];
      end else begin : g_operator
         logic [2*WIDTH-1:0] full;
         logic [WIDTH-1:0]   unused_hi;
         assign full      = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
         assign prod_lo   = full[WIDTH-1:0];
         assign unused_hi = full[2*WIDTH-1:WIDTH];
      end
   endgenerate
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] amt,
   output logic [WIDTH-1:0] lsl,
   output logic [WIDTH-1:0] lsr,
   output logic [WIDTH-1:0] asl,
   output logic [WIDTH-1:0] asr,
   output logic             asl_v
);
   localparam int             SH_W  = $clog2(WIDTH);
   localparam logic [WIDTH-1:0] W_VEC = WIDTH'(WIDTH);

   logic            big;
   logic [SH_W-1:0] sh;

   always_comb begin
      big = (amt >= W_VEC);
      sh  = amt[SH_W-1:0];
      if (big) begin
         lsl   = '0;
         lsr   = '0;
         asl   = '0;
         asr   = {WIDTH{a[WIDTH-1]}};
         asl_v = |a;
      end else begin
         lsl   = a << sh;
         lsr   = a >> sh;
         asl   = a << sh;
         asr   = WIDTH'($signed(a) >>> sh);
         // shifting back must restore a when no sign information was lost
         asl_v = (WIDTH'($signed(asl) >>> sh) != a);
      end
   end
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
   import alu_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   en,
   input  flags_t mask,
   input  flags_t nxt,
   output flags_t q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (en) begin
         if (mask.c) q.c <= nxt.c;
         if (mask.v) q.v <= nxt.v;
         if (mask.z) q.z <= nxt.z;
      end
   end
endmodule

// File: rtl/alu16_flagsel.sv
module alu16_flagsel
   import alu_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter bit MUL_ARRAY = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [3:0]       func,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] result,
   output logic             flag_c,
   output logic             flag_v,
   output logic             flag_z
);
   if (WIDTH < 4) begin : g_width_chk
      $error("alu16_flagsel: WIDTH must be at least 4");
   end

   logic [WIDTH-1:0] sum, diff, prod, lsl, lsr, asl, asr;
   logic             sum_c, sum_v, diff_c, diff_v, asl_v;
   flags_t           mask, nxt, q;

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a(opa), .b(opb),
      .sum(sum), .sum_c(sum_c), .sum_v(sum_v),
      .diff(diff), .diff_c(diff_c), .diff_v(diff_v)
   );

   alu_multlo #(.WIDTH(WIDTH), .MUL_ARRAY(MUL_ARRAY)) u_mul (
      .a(opa), .b(opb), .prod_lo(prod)
   );

   alu_shifter #(.WIDTH(WIDTH)) u_shift (
      .a(opa), .amt(opb),
      .lsl(lsl), .lsr(lsr), .asl(asl), .asr(asr), .asl_v(asl_v)
   );

   always_comb begin
      nxt = '0;
      case (func)
         OP_ADD: begin result = sum;  nxt.c = sum_c;  nxt.v = sum_v;  end
         OP_SUB: begin result = diff; nxt.c = diff_c; nxt.v = diff_v; end
         OP_MUL: result = prod;
         OP_AND: result = opa & opb;
         OP_OR:  result = opa | opb;
         OP_XOR: result = opa ^ opb;
         OP_NOT: result = ~opb;
         OP_LSL: result = lsl;
         OP_LSR: result = lsr;
         OP_ASL: begin result = asl; nxt.v = asl_v; end
         OP_ASR: result = asr;
         OP_MOV: result = opb;
         default: result = opa;
      endcase
      nxt.z = (result == '0);
      mask  = flag_mask(func);
   end

   alu_flagreg u_flags (
      .clk(clk), .rst(rst), .en(en), .mask(mask), .nxt(nxt), .q(q)
   );

   assign flag_c = q.c;
   assign flag_v = q.v;
   assign flag_z = q.z;
endmodule

// File: rtl/alu16_flagsel_chk.sv
module alu16_flagsel_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [3:0]       func,
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [WIDTH-1:0] result,
   input logic             flag_c,
   input logic             flag_v,
   input logic             flag_z
);
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable({flag_c, flag_v, flag_z}));                            // R9

   AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (en && (func == 4'd0 || func > 4'd12)) |=> $stable({flag_c, flag_v, flag_z})); // R8

   AST_KEEP_CV: assert property (@(posedge clk) disable iff (rst)
      (en && (func inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd11, 4'd12}))
      |=> ($stable(flag_c) && $stable(flag_v)));                               // R7

   AST_ASL_KEEP_C: assert property (@(posedge clk) disable iff (rst)
      (en && func == 4'd10) |=> $stable(flag_c));                              // R6

   AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
      (en && func == 4'd2) |=> (flag_c == ($past(opa) < $past(opb))));         // R5

   AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
      (en && func >= 4'd1 && func <= 4'd12) |=> (flag_z == ($past(result) == '0))); // R4

   AST_MOV_PASS: assert property (@(posedge clk) disable iff (rst)
      (func == 4'd12) |-> (result == opb));                                    // R1

   AST_NOP_PASS: assert property (@(posedge clk) disable iff (rst)
      (func == 4'd0) |-> (result == opa));                                     // R8
endmodule

bind alu16_flagsel alu16_flagsel_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu16_flagsel.sv
`timescale 1ns/1ps
module sim_alu16_flagsel;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [3:0]  func = '0;
   logic [15:0] opa = '0, opb = '0;
   logic [15:0] result;
   logic        flag_c, flag_v, flag_z;

   int n_cmp = 0, n_bad = 0;
   logic ec = 1'b0, ev = 1'b0, ez = 1'b0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   alu16_flagsel u0 (.*);

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic asl_ovf(input logic [15:0] a, input logic [15:0] b);
      int  s  = (b >= 16) ? 16 : int'(b);
      logic ov = 1'b0;
      for (int i = 0; i < s; i++) if (a[15 - i] != a[15]) ov = 1'b1;
      if (s < 16) begin
         if (a[15 - s] != a[15]) ov = 1'b1;
      end else if (a[15]) ov = 1'b1;
      return ov;
   endfunction

   task automatic model(input logic [3:0] f, input logic [15:0] a, b,
                        output logic [15:0] r, output logic nc, nv,
                        output logic mc, mv, mz, output string rt, ft);
      logic [16:0] w;
      logic [31:0] p;
      nc = 0; nv = 0; mc = 0; mv = 0; mz = 1; rt = "R1"; ft = "R7";
      case (f)
         4'd1: begin w = {1'b0,a} + {1'b0,b}; r = w[15:0]; nc = w[16];
                     nv = (a[15] == b[15]) && (r[15] != a[15]);
                     mc = 1; mv = 1; ft = "R4"; end
         4'd2: begin r = a - b; nc = (a < b);
                     nv = (a[15] != b[15]) && (r[15] != a[15]);
                     mc = 1; mv = 1; ft = "R5"; end
         4'd3: begin p = {16'd0, a} * {16'd0, b}; r = p[15:0]; end
         4'd4: r = a & b;
         4'd5: r = a | b;
         4'd6: r = a ^ b;
         4'd7: r = ~b;
         4'd8: begin r = (b >= 16) ? 16'd0 : a << b[3:0]; rt = "R2"; end
         4'd9: begin r = (b >= 16) ? 16'd0 : a >> b[3:0]; rt = "R2"; end
         4'd10: begin r = (b >= 16) ? 16'd0 : a << b[3:0]; nv = asl_ovf(a, b);
                      mv = 1; rt = "R3"; ft = "R6"; end
         4'd11: begin
                   r = a;
                   for (int i = 0; i < 16 && i < int'(b); i++) r = {a[15], r[15:1]};
                   rt = "R3";
                end
         4'd12: r = b;
         default: begin r = a; mz = 0; rt = "R8"; ft = "R8"; end
      endcase
   endtask

   task automatic run(input logic [3:0] f, input logic [15:0] a, b, input logic e);
      logic [15:0] er; logic nc, nv, mc, mv, mz; string rt, ft;
      @(negedge clk);
      func = f; opa = a; opb = b; en = e;
      model(f, a, b, er, nc, nv, mc, mv, mz, rt, ft);
      #1;
      chk(result === er, rt, "result", result, er);
      if (e) begin
         if (mc) ec = nc;
         if (mv) ev = nv;
         if (mz) ez = (er == 16'd0);
      end else ft = "R9";
      @(posedge clk); #1;
      chk({flag_c, flag_v, flag_z} === {ec, ev, ez}, ft, "flags CVZ",
          {13'd0, flag_c, flag_v, flag_z}, {13'd0, ec, ev, ez});
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed);
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      chk({flag_c, flag_v, flag_z} === 3'b000, "R10", "reset flags",
          {13'd0, flag_c, flag_v, flag_z}, 16'd0);

      // R4 add boundaries
      run(4'd1, 16'h7FFF, 16'h0001, 1);
      run(4'd1, 16'hFFFF, 16'h0001, 1);
      run(4'd1, 16'h8000, 16'h8000, 1);
      // R7 XOR keeps carry and overflow from previous add
      run(4'd6, 16'h1234, 16'h1234, 1);
      run(4'd6, 16'h1234, 16'h0004, 1);
      // R5 subtract
      run(4'd2, 16'h0000, 16'h0001, 1);
      run(4'd2, 16'h8000, 16'h0001, 1);
      run(4'd2, 16'h5555, 16'h5555, 1);
      // R1 multiply low half
      run(4'd3, 16'h0123, 16'h0100, 1);
      run(4'd3, 16'hFFFF, 16'hFFFF, 1);
      // R2 logical shifts at the saturation boundary
      run(4'd8, 16'h8001, 16'd15, 1);
      run(4'd8, 16'h8001, 16'd16, 1);
      run(4'd9, 16'h8001, 16'hFFFF, 1);
      // R3 arithmetic right shift with sign fill
      run(4'd11, 16'h8000, 16'd15, 1);
      run(4'd11, 16'h8000, 16'd40, 1);
      run(4'd11, 16'h4000, 16'd3, 1);
      // R6 arithmetic shift left overflow
      run(4'd10, 16'h4000, 16'd1, 1);
      run(4'd10, 16'hC000, 16'd1, 1);
      run(4'd10, 16'hFFFF, 16'd16, 1);
      run(4'd10, 16'h0000, 16'd20, 1);
      // R8 no-operation and unused codes
      run(4'd2, 16'h0000, 16'h0001, 1);
      run(4'd0, 16'hABCD, 16'h0000, 1);
      run(4'd15, 16'h0000, 16'h1111, 1);
      // R9 enable low
      run(4'd1, 16'h0000, 16'h0000, 0);
      // R1 NOT, move
      run(4'd7, 16'h0000, 16'hFFFF, 1);
      run(4'd12, 16'h0000, 16'h00F0, 1);

      for (int k = 0; k < 4000; k++) begin
         logic [3:0]  f = 4'($urandom % 16);
         logic [15:0] a = 16'($urandom);
         logic [15:0] b = 16'($urandom);
         if (f >= 4'd8 && f <= 4'd11 && ($urandom % 4) != 0) b = 16'($urandom % 20);
         if (($urandom % 8) == 0) a = {16{a[0]}};
         run(f, a, b, ($urandom % 5) != 0);
      end

      // R10 reset in mid-run
      run(4'd1, 16'hFFFF, 16'hFFFF, 1);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      ec = 0; ev = 0; ez = 0;
      chk({flag_c, flag_v, flag_z} === 3'b000, "R10", "mid-run reset flags",
          {13'd0, flag_c, flag_v, flag_z}, 16'd0);
      @(negedge clk); rst = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule